// File: doc/BRIEF.md
# Floating-Point Register Stack Push Unit

This block keeps eight 80-bit extended-precision floating-point values in a circular register file. Entries are addressed relative to a 3-bit top pointer, and each entry carries a valid tag. A one-cycle push strobe stores a new value on the stack. The value comes either from an 80-bit input or from a stack-relative register ST(i), counted from the current top. The block moves the top pointer down by one and tags the new top entry valid.

The block checks two stack fault conditions on every push: pushing onto an occupied entry (overflow) and reading an empty ST(i) (underflow). On a fault it raises a stack-fault flag, and a condition bit tells overflow apart from underflow. The invalid-operation mask input decides the outcome of a faulting push. When the fault is masked, the block stores the default quiet NaN. When it is unmasked, the stack is left untouched. A simple pop strobe is included so the stack can be emptied and its contents inspected.

Top module: `fpstk_push`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `top_ptr_o`=0, `top_tag_o`=0, `done_o`=0, `stk_fault_o`=0 and `c1_o`=0, and every entry is tagged empty.
- R2: A non-faulting push of an external value (`push_src_i`=0) sets `top_ptr_o` to the old pointer minus one, modulo 8 (0 goes to 7). In the cycle after the strobe, `top_val_o` equals `push_data_i` and `top_tag_o`=1.
- R3: A push with `push_src_i`=1 copies the entry at (old pointer + `push_idx_i`) mod 8, read before the pointer moves.
- R4: Pushing ST(0) (`push_idx_i`=0) leaves the new top and the entry below it holding the same value.
- R5: A push whose destination entry (old pointer − 1) is already tagged valid is an overflow. It gives `stk_fault_o`=1 and `c1_o`=1.
- R6: A register-source push whose ST(i) entry is tagged empty, with no overflow, is an underflow. It gives `stk_fault_o`=1 and `c1_o`=0.
- R7: On a faulting push with `inv_mask_i`=1, the pointer still moves. The new top holds the quiet NaN 0xFFFF_C000_0000_0000_0000 and is tagged valid.
- R8: On a faulting push with `inv_mask_i`=0, the pointer, the top value and the tags are left unchanged.
- R9: `done_o` is high for exactly the one cycle after each push strobe, and stays low after a pop. `stk_fault_o` and `c1_o` are updated together with it.
- R10: A pop (`pop_i`, with no push in the same cycle) tags the current top empty and increments the pointer. The new top's value and tag appear on `top_val_o` and `top_tag_o`. A pop in the same cycle as a push is ignored.
- R11: A non-faulting push clears both `stk_fault_o` and `c1_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | One-cycle push strobe |
| push_src_i | input | 1 | 0: external value, 1: stack register ST(i) |
| push_idx_i | input | 3 | Stack-relative index i of the source register |
| push_data_i | input | 80 | External value to push |
| pop_i | input | 1 | One-cycle pop strobe |
| inv_mask_i | input | 1 | 1: invalid-operation fault masked |
| top_ptr_o | output | 3 | Current top-of-stack pointer |
| top_val_o | output | 80 | Value of the current top entry |
| top_tag_o | output | 1 | Valid tag of the current top entry |
| done_o | output | 1 | High for one cycle after a push |
| stk_fault_o | output | 1 | Stack fault seen on the last push |
| c1_o | output | 1 | 1 if that fault was an overflow |

## Verification
Every result is a register loaded on the same edge that samples the strobe. The pointer, top value, tag, done pulse and fault bits are therefore all due exactly one cycle after a push or pop. The bench drives each strobe on a falling edge and removes it on the next falling edge. It reads all outputs at that same falling edge, half a cycle after the update, and checks once more a cycle later that `done_o` has dropped. Entries below the top are observed by popping them, so each pop result is also read one cycle after its strobe.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  localparam int FP_W  = 80;
  localparam int EXP_W = 15;
  localparam int DEPTH = 8;

  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_REG = 1'b1
  } push_src_e;
endpackage

// File: rtl/fpstk_ptr.sv
module fpstk_ptr #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_en,
  input  logic          inc_en,
  input  logic [PW-1:0] idx,
  output logic [PW-1:0] ptr_q,
  output logic [PW-1:0] ptr_dec,
  output logic [PW-1:0] ptr_inc,
  output logic [PW-1:0] src_addr
);
  assign ptr_dec  = ptr_q - PW'(1);
  assign ptr_inc  = ptr_q + PW'(1);
  assign src_addr = ptr_q + idx;

  always_ff @(posedge clk) begin
    if (rst)         ptr_q <= '0;
    else if (dec_en) ptr_q <= ptr_dec;
    else if (inc_en) ptr_q <= ptr_inc;
  end

  // R2
  ptr_dec_chk: assert property (@(posedge clk) disable iff (rst)
    dec_en |=> (ptr_q == $past(ptr_q) - PW'(1)));
  // R10
  ptr_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_en && !dec_en) |=> (ptr_q == $past(ptr_q) + PW'(1)));
  // R1
  ptr_rst_chk: assert property (@(posedge clk) rst |=> (ptr_q == '0));
endmodule

// File: rtl/fpstk_tags.sv
module fpstk_tags #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [PW-1:0]    set_addr,
  input  logic             clr_en,
  input  logic [PW-1:0]    clr_addr,
  output logic [DEPTH-1:0] tag_q
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    always_ff @(posedge clk) begin
      if (rst)                                   tag_q[g] <= 1'b0;
      else if (set_en && set_addr == PW'(g))     tag_q[g] <= 1'b1;
      else if (clr_en && clr_addr == PW'(g))     tag_q[g] <= 1'b0;
    end
  end

  // R1
  tags_rst_chk: assert property (@(posedge clk) rst |=> (tag_q == '0));
  // R7
  tags_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |=> tag_q[$past(set_addr)]);
endmodule

// File: rtl/fpstk_regfile.sv
module fpstk_regfile #(
  parameter int DEPTH = 8,
  parameter int W = 80,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [PW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [PW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/fpstk_push.sv
module fpstk_push
  import fpstk_pkg::*;
#(
  parameter int DEPTH_P = fpstk_pkg::DEPTH,
  parameter int W       = fpstk_pkg::FP_W,
  parameter int EW      = fpstk_pkg::EXP_W,
  localparam int PW = $clog2(DEPTH_P)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          push_src_i,
  input  logic [PW-1:0] push_idx_i,
  input  logic [W-1:0]  push_data_i,
  input  logic          pop_i,
  input  logic          inv_mask_i,
  output logic [PW-1:0] top_ptr_o,
  output logic [W-1:0]  top_val_o,
  output logic          top_tag_o,
  output logic          done_o,
  output logic          stk_fault_o,
  output logic          c1_o
);
  localparam logic [W-1:0] QNAN = {1'b1, {EW{1'b1}}, 2'b11, {(W-EW-3){1'b0}}};

  logic [PW-1:0]      ptr_q, ptr_dec, ptr_inc, src_addr;
  logic [DEPTH_P-1:0] tag_q;
  logic [W-1:0]       src_val, inc_val, wdata;
  logic               ovf, unf, fault, commit, do_pop;
  push_src_e          src;

  assign src    = push_src_e'(push_src_i);
  assign ovf    = tag_q[ptr_dec];
  assign unf    = (src == SRC_REG) && !tag_q[src_addr];
  assign fault  = ovf || unf;
  assign commit = push_i && (!fault || inv_mask_i);
  assign do_pop = pop_i && !push_i;

  always_comb begin
    if (fault)               wdata = QNAN;
    else if (src == SRC_REG) wdata = src_val;
    else                     wdata = push_data_i;
  end

  fpstk_ptr #(.DEPTH(DEPTH_P)) u_ptr (
    .clk(clk), .rst(rst), .dec_en(commit), .inc_en(do_pop),
    .idx(push_idx_i), .ptr_q(ptr_q), .ptr_dec(ptr_dec),
    .ptr_inc(ptr_inc), .src_addr(src_addr)
  );

  fpstk_tags #(.DEPTH(DEPTH_P)) u_tags (
    .clk(clk), .rst(rst), .set_en(commit), .set_addr(ptr_dec),
    .clr_en(do_pop), .clr_addr(ptr_q), .tag_q(tag_q)
  );

  fpstk_regfile #(.DEPTH(DEPTH_P), .W(W)) u_rf (
    .clk(clk), .we(commit), .waddr(ptr_dec), .wdata(wdata),
    .raddr_a(src_addr), .rdata_a(src_val),
    .raddr_b(ptr_inc), .rdata_b(inc_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      top_val_o   <= '0;
      top_tag_o   <= 1'b0;
      done_o      <= 1'b0;
      stk_fault_o <= 1'b0;
      c1_o        <= 1'b0;
    end else begin
      done_o <= push_i;
      if (push_i) begin
        stk_fault_o <= fault;
        c1_o        <= ovf;
      end
      if (commit) begin
        top_val_o <= wdata;
        top_tag_o <= 1'b1;
      end else if (do_pop) begin
        top_val_o <= inc_val;
        top_tag_o <= tag_q[ptr_inc];
      end
    end
  end

  assign top_ptr_o = ptr_q;

  // R5
  c1_needs_fault_chk: assert property (@(posedge clk) disable iff (rst)
    c1_o |-> stk_fault_o);
  // R9
  fault_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stk_fault_o) |-> done_o);
  // R8
  unmasked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && fault && !inv_mask_i) |=> ($stable(top_ptr_o) && $stable(top_val_o)));
  // R10
  pop_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i && !commit) |=> $stable(top_ptr_o));
endmodule

// File: tb/tb_fpstk_push.sv
module tb_fpstk_push;
  logic        clk = 1'b0;
  logic        rst;
  logic        push_i, push_src_i, pop_i, inv_mask_i;
  logic [2:0]  push_idx_i;
  logic [79:0] push_data_i;
  logic [2:0]  top_ptr_o;
  logic [79:0] top_val_o;
  logic        top_tag_o, done_o, stk_fault_o, c1_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  localparam logic [79:0] QNAN = 80'hFFFF_C000_0000_0000_0000;

  always #10 clk = ~clk;

  fpstk_push dut (
    .clk(clk), .rst(rst), .push_i(push_i), .push_src_i(push_src_i),
    .push_idx_i(push_idx_i), .push_data_i(push_data_i), .pop_i(pop_i),
    .inv_mask_i(inv_mask_i), .top_ptr_o(top_ptr_o), .top_val_o(top_val_o),
    .top_tag_o(top_tag_o), .done_o(done_o), .stk_fault_o(stk_fault_o), .c1_o(c1_o)
  );

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_state(input string req, input logic [2:0] ptr, input logic [79:0] val,
                              input bit tag, input bit dn, input bit flt, input bit c1);
    chk(top_ptr_o == ptr, {req, " ptr"}, 80'(top_ptr_o), 80'(ptr));
    chk(top_val_o == val, {req, " val"}, top_val_o, val);
    chk(top_tag_o == tag, {req, " tag"}, 80'(top_tag_o), 80'(tag));
    chk(done_o == dn, {req, " done"}, 80'(done_o), 80'(dn));
    chk(stk_fault_o == flt, {req, " fault"}, 80'(stk_fault_o), 80'(flt));
    chk(c1_o == c1, {req, " c1"}, 80'(c1_o), 80'(c1));
  endtask

  task automatic do_push(input bit src, input logic [2:0] idx, input logic [79:0] d,
                         input bit mask, input bit also_pop);
    push_i = 1'b1; push_src_i = src; push_idx_i = idx; push_data_i = d;
    inv_mask_i = mask; pop_i = also_pop;
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0;
  endtask

  task automatic do_pop();
    pop_i = 1'b1;
    @(negedge clk);
    pop_i = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    // R1
    chk(top_ptr_o == 3'd0, "R1 ptr", 80'(top_ptr_o), 80'd0);
    chk(top_tag_o == 1'b0, "R1 tag", 80'(top_tag_o), 80'd0);
    chk(!done_o && !stk_fault_o && !c1_o, "R1 status", 80'({done_o, stk_fault_o, c1_o}), 80'd0);
  endtask

  task automatic t_push_ext();
    do_push(1'b0, 3'd0, 80'h4000_A000_0000_0000_0001, 1'b1, 1'b0);
    expect_state("R2 first push wraps", 3'd7, 80'h4000_A000_0000_0000_0001, 1, 1, 0, 0);
    do_push(1'b0, 3'd0, 80'h3FFF_8000_0000_0000_00BB, 1'b1, 1'b0);
    expect_state("R2 second push", 3'd6, 80'h3FFF_8000_0000_0000_00BB, 1, 1, 0, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done one cycle", 80'(done_o), 80'd0);
  endtask

  task automatic t_push_reg();
    // entries: 7=A, 6=B; ST(1) is A
    do_push(1'b1, 3'd1, 80'h0, 1'b1, 1'b0);
    expect_state("R3 push ST1", 3'd5, 80'h4000_A000_0000_0000_0001, 1, 1, 0, 0);
    do_push(1'b1, 3'd0, 80'h0, 1'b1, 1'b0);
    expect_state("R4 push ST0", 3'd4, 80'h4000_A000_0000_0000_0001, 1, 1, 0, 0);
    do_pop();
    expect_state("R4 copy below", 3'd5, 80'h4000_A000_0000_0000_0001, 1, 0, 0, 0);
    do_pop();
    expect_state("R10 pop to B", 3'd6, 80'h3FFF_8000_0000_0000_00BB, 1, 0, 0, 0);
    do_pop();
    expect_state("R10 pop to A", 3'd7, 80'h4000_A000_0000_0000_0001, 1, 0, 0, 0);
    do_pop();
    chk(top_ptr_o == 3'd0, "R10 pop wrap ptr", 80'(top_ptr_o), 80'd0);
    chk(top_tag_o == 1'b0, "R10 pop empty tag", 80'(top_tag_o), 80'd0);
  endtask

  task automatic t_underflow();
    // stack empty, ptr 0
    do_push(1'b1, 3'd3, 80'h0, 1'b1, 1'b0);
    expect_state("R6 R7 masked underflow", 3'd7, QNAN, 1, 1, 1, 0);
    do_push(1'b1, 3'd2, 80'h0, 1'b0, 1'b0);
    expect_state("R8 unmasked underflow", 3'd7, QNAN, 1, 1, 1, 0);
    do_push(1'b0, 3'd0, 80'h1234_5678_9ABC_DEF0_1357, 1'b0, 1'b0);
    expect_state("R11 clean push clears", 3'd6, 80'h1234_5678_9ABC_DEF0_1357, 1, 1, 0, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int k = 0; k < 8; k++) begin
      do_push(1'b0, 3'd0, 80'(64'hD000 + k), 1'b1, 1'b0);
      expect_state("R2 fill", 3'(7 - k), 80'(64'hD000 + k), 1, 1, 0, 0);
    end
    do_push(1'b0, 3'd0, 80'hEEEE, 1'b0, 1'b0);
    expect_state("R5 R8 unmasked overflow", 3'd0, 80'hD007, 1, 1, 1, 1);
    do_push(1'b0, 3'd0, 80'hEEEE, 1'b1, 1'b0);
    expect_state("R5 R7 masked overflow", 3'd7, QNAN, 1, 1, 1, 1);
    do_pop();
    expect_state("R10 pop after overflow", 3'd0, 80'hD007, 1, 0, 1, 1);
    do_push(1'b0, 3'd0, 80'hF00D, 1'b1, 1'b1);
    expect_state("R10 R11 pop ignored with push", 3'd7, 80'hF00D, 1, 1, 0, 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; push_i = 1'b0; push_src_i = 1'b0; push_idx_i = '0;
    push_data_i = '0; pop_i = 1'b0; inv_mask_i = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_ext();
    t_push_reg();
    t_underflow();
    t_overflow();
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule